// File: doc/BRIEF.md
# Word-Streaming Transfer Buffer

This block holds 512 bytes of transfer data shared by two clients. A processor reaches it through a 32-bit register port with two registers: a control register and a data register. The control register holds a direction flag, an auto-advance flag and a word pointer. Each access to the data register moves one 32-bit word at the pointer. When auto-advance is set, the pointer then steps to the next word, so a whole payload can be streamed through one register address.

The other client is a serial transfer engine. It reaches the same storage one byte at a time, using a byte address, while it shifts data in or out of the device. Software fills the buffer before an outgoing data phase and drains it after an incoming one. A payload whose length is not a multiple of four ends with one full word access, and only the low bytes of that word carry data.

Top module: `wbuf_port`

## Requirements
- R1: After reset the control register reads 0 (read direction, auto-advance off, pointer 0), and `cpu_rdata` is 0.
- R2: The control register is selected by `cpu_sel`=0. Bit 31 is the direction (1: the processor writes the buffer, 0: the processor reads it), bit 30 enables auto-advance, and bits 6:0 load the word pointer. Bit 7 and all other bits are discarded, and they read back as 0.
- R3: The data register is selected by `cpu_sel`=1. A write while the direction is 1 stores the word at the pointer. A read returns the word at the pointer on `cpu_rdata` one cycle after the request.
- R4: With auto-advance on, each accepted data read or data write increments the pointer by one word.
- R5: When auto-advance steps the pointer past word 127, it wraps to word 0.
- R6: With auto-advance off, the pointer does not move, and repeated data accesses reach the same word.
- R7: A data write while the direction is 0 is ignored. The buffer contents and the pointer are left unchanged.
- R8: A data read while the direction is 1 returns the word at the pointer and leaves the contents unchanged. The pointer advances if auto-advance is on.
- R9: Bytes are little-endian. Engine byte address A is word A/4, bits 8*(A mod 4)+7 down to 8*(A mod 4). A partial tail word written as a full word shows its low bytes at the lowest byte addresses.
- R10: An engine write (`eng_en`=1, `eng_we`=1) changes only the addressed byte. An engine read returns the addressed byte on `eng_rdata` one cycle later.
- R11: When an engine write and a processor data access hit the same word in the same cycle, the engine wins. A processor read returns the value from before the engine write. A processor write to that word is discarded in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access strobe, one cycle per access |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, valid the cycle after a read |
| eng_en | input | 1 | Engine byte access strobe |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 9 | Engine byte address |
| eng_wdata | input | 8 | Engine write byte |
| eng_rdata | output | 8 | Engine read byte, valid the cycle after a read |

## Verification
Words are streamed with distinct values at several starting pointers, with auto-advance on and off. This shows whether the pointer steps, holds or wraps at the last word. Data writes issued under the wrong direction, and reads issued in write mode, show that the direction flag gates only stores. Engine byte reads of a word written by the processor, and engine byte writes that the processor then reads back, fix the lane order. Processor and engine accesses issued in the same cycle to the same word show which side wins, and whether the processor sees the old value.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int BUF_BYTES  = 512;
  localparam int WORD_BYTES = 4;
  localparam int WORDS      = BUF_BYTES / WORD_BYTES;
  localparam int PTR_W      = $clog2(WORDS);
  localparam int BADDR_W    = $clog2(BUF_BYTES);
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam int DIR_BIT    = 31;
  localparam int AUTO_BIT   = 30;

  // Next pointer after a data access: wraps naturally at WORDS
  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p,
                                                input logic adv);
    return adv ? PTR_W'(p + 1'b1) : p;
  endfunction

  function automatic logic [PTR_W-1:0] word_of(input logic [BADDR_W-1:0] a);
    return a[BADDR_W-1:LANE_W];
  endfunction

  function automatic logic [LANE_W-1:0] lane_of(input logic [BADDR_W-1:0] a);
    return a[LANE_W-1:0];
  endfunction

  // Read-back image of the control register
  function automatic logic [31:0] ctrl_image(input logic dir_wr, input logic adv,
                                             input logic [PTR_W-1:0] p);
    logic [31:0] v;
    v = '0;
    v[DIR_BIT]      = dir_wr;
    v[AUTO_BIT]     = adv;
    v[PTR_W-1:0]    = p;
    return v;
  endfunction
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [31:0]      ctrl_wdata,
  input  logic             data_acc,
  output logic             dir_wr,
  output logic             auto_inc,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_wr   <= 1'b0;
      auto_inc <= 1'b0;
      ptr      <= '0;
    end else if (ctrl_wr) begin
      dir_wr   <= ctrl_wdata[DIR_BIT];
      auto_inc <= ctrl_wdata[AUTO_BIT];
      ptr      <= ctrl_wdata[PTR_W-1:0];
    end else if (data_acc) begin
      ptr      <= next_ptr(ptr, auto_inc);
    end
  end

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ptr == $past(ctrl_wdata[PTR_W-1:0]));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ctrl_wr && auto_inc && ptr == PTR_W'(WORDS-1)) |=> ptr == '0);

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ctrl_wr && !auto_inc) |=> $stable(ptr));
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [PTR_W-1:0]   cpu_idx,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_q,
  input  logic               eng_en,
  input  logic               eng_we,
  input  logic [BADDR_W-1:0] eng_addr,
  input  logic [7:0]         eng_wdata,
  output logic [7:0]         eng_q,
  output logic               clash
);
  logic [31:0] mem [WORDS];

  logic [PTR_W-1:0]  eng_word;
  logic [LANE_W-1:0] eng_lane;
  logic              eng_wr;
  logic              cpu_wr_ok;

  assign eng_word  = word_of(eng_addr);
  assign eng_lane  = lane_of(eng_addr);
  assign eng_wr    = eng_en & eng_we;
  assign clash     = eng_wr & (cpu_rd | cpu_wr) & (eng_word == cpu_idx);
  assign cpu_wr_ok = cpu_wr & ~clash;

  always_ff @(posedge clk) begin
    if (eng_wr)    mem[eng_word][{eng_lane, 3'b000} +: 8] <= eng_wdata;
    if (cpu_wr_ok) mem[cpu_idx] <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= '0;
      eng_q <= '0;
    end else begin
      if (cpu_rd)           cpu_q <= mem[cpu_idx];
      if (eng_en && !eng_we) eng_q <= mem[eng_word][{eng_lane, 3'b000} +: 8];
    end
  end

  // Capture of a contested engine write, used only by the assertion below
  logic              chk_v;
  logic [PTR_W-1:0]  chk_word;
  logic [LANE_W-1:0] chk_lane;
  logic [7:0]        chk_byte;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v <= 1'b0; chk_word <= '0; chk_lane <= '0; chk_byte <= '0;
    end else begin
      chk_v    <= clash & cpu_wr;
      chk_word <= eng_word;
      chk_lane <= eng_lane;
      chk_byte <= eng_wdata;
    end
  end

  // R11
  eng_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> mem[chk_word][{chk_lane, 3'b000} +: 8] == chk_byte);
endmodule

// File: rtl/wbuf_port.sv
module wbuf_port
  import wbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic               cpu_sel,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  input  logic               eng_en,
  input  logic               eng_we,
  input  logic [BADDR_W-1:0] eng_addr,
  input  logic [7:0]         eng_wdata,
  output logic [7:0]         eng_rdata
);
  logic             dir_wr, auto_inc;
  logic [PTR_W-1:0] ptr;
  logic             ctrl_wr, ctrl_rd, data_rd, data_wr, data_wr_dropped, data_acc;
  logic             clash;
  logic [31:0]      word_q, ctrl_q;
  logic             sel_q;

  assign ctrl_wr         = cpu_req &  cpu_we & ~cpu_sel;
  assign ctrl_rd         = cpu_req & ~cpu_we & ~cpu_sel;
  assign data_rd         = cpu_req & ~cpu_we &  cpu_sel;
  assign data_wr         = cpu_req &  cpu_we &  cpu_sel &  dir_wr;
  assign data_wr_dropped = cpu_req &  cpu_we &  cpu_sel & ~dir_wr;
  assign data_acc        = data_rd | data_wr;

  wbuf_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(cpu_wdata),
    .data_acc(data_acc), .dir_wr(dir_wr), .auto_inc(auto_inc), .ptr(ptr)
  );

  wbuf_store i_store (
    .clk(clk), .rst_n(rst_n), .cpu_rd(data_rd), .cpu_wr(data_wr),
    .cpu_idx(ptr), .cpu_wdata(cpu_wdata), .cpu_q(word_q),
    .eng_en(eng_en), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_q(eng_rdata), .clash(clash)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (ctrl_rd) ctrl_q <= ctrl_image(dir_wr, auto_inc, ptr);
      if (ctrl_rd || data_rd) sel_q <= data_rd;
    end
  end

  assign cpu_rdata = sel_q ? word_q : ctrl_q;

  // R7
  dropped_write_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_dropped |=> $stable(ptr));

  // R4
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && auto_inc) |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R1
  rdata_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> cpu_rdata == '0);
endmodule

// File: tb/test_wbuf_port.sv
`timescale 1ns/1ps
module test_wbuf_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0, cpu_sel = 0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        eng_en = 0, eng_we = 0;
  logic [8:0]  eng_addr = '0;
  logic [7:0]  eng_wdata = '0;
  logic [7:0]  eng_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wbuf_port i_wbuf_port (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .eng_en(eng_en), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // One processor access; result sampled the cycle after the request
  task automatic cpu(input logic sel, input logic we, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    cpu_req = 1; cpu_sel = sel; cpu_we = we; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    q = cpu_rdata;
  endtask

  task automatic set_ctrl(input logic dw, input logic adv, input int p);
    logic [31:0] q;
    cpu(0, 1, {dw, adv, 22'd0, 8'(p)}, q);
  endtask

  function automatic logic [31:0] img(input logic dw, input logic adv, input int p);
    return {dw, adv, 23'd0, 7'(p)};
  endfunction

  task automatic eng(input logic we, input int a, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    eng_en = 1; eng_we = we; eng_addr = 9'(a); eng_wdata = d;
    @(negedge clk);
    eng_en = 0; eng_we = 0;
    q = eng_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] q;
    chk("R1 rdata", cpu_rdata, 32'h0);
    cpu(0, 0, 0, q);
    chk("R1 ctrl", q, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] q;
    cpu(0, 1, 32'hFFFF_FF85, q);
    cpu(0, 0, 0, q);
    chk("R2 ctrl image", q, 32'hC000_0005);
  endtask

  task automatic t_stream();
    logic [31:0] q;
    set_ctrl(1, 1, 10);
    for (int i = 0; i < 3; i++) cpu(1, 1, 32'hA000_0000 + i, q);
    cpu(0, 0, 0, q);
    chk("R4 ptr after writes", q, img(1, 1, 13));
    set_ctrl(0, 1, 10);
    for (int i = 0; i < 3; i++) begin
      cpu(1, 0, 0, q);
      chk("R3 stream read", q, 32'hA000_0000 + i);
    end
  endtask

  task automatic t_wrap();
    logic [31:0] q;
    set_ctrl(1, 1, 127);
    cpu(1, 1, 32'h1111_7F7F, q);
    cpu(1, 1, 32'h2222_0000, q);
    cpu(0, 0, 0, q);
    chk("R5 ptr wrapped", q, img(1, 1, 1));
    set_ctrl(0, 1, 127);
    cpu(1, 0, 0, q); chk("R5 word 127", q, 32'h1111_7F7F);
    cpu(1, 0, 0, q); chk("R5 word 0", q, 32'h2222_0000);
  endtask

  task automatic t_noauto();
    logic [31:0] q;
    set_ctrl(1, 0, 20);
    cpu(1, 1, 32'hDEAD_0001, q);
    cpu(1, 1, 32'hBEEF_0002, q);
    cpu(0, 0, 0, q);
    chk("R6 ptr held", q, img(1, 0, 20));
    set_ctrl(0, 0, 20);
    cpu(1, 0, 0, q); chk("R6 same word", q, 32'hBEEF_0002);
    cpu(1, 0, 0, q); chk("R6 same word again", q, 32'hBEEF_0002);
  endtask

  task automatic t_ignore();
    logic [31:0] q;
    set_ctrl(0, 1, 20);
    cpu(1, 1, 32'h5555_5555, q);
    cpu(0, 0, 0, q);
    chk("R7 ptr unchanged", q, img(0, 1, 20));
    cpu(1, 0, 0, q);
    chk("R7 contents unchanged", q, 32'hBEEF_0002);
  endtask

  task automatic t_rd_in_wr();
    logic [31:0] q;
    set_ctrl(1, 1, 20);
    cpu(1, 0, 0, q);
    chk("R8 read in write mode", q, 32'hBEEF_0002);
    cpu(0, 0, 0, q);
    chk("R8 ptr advanced", q, img(1, 1, 21));
    set_ctrl(0, 0, 20);
    cpu(1, 0, 0, q);
    chk("R8 contents unchanged", q, 32'hBEEF_0002);
  endtask

  task automatic t_endian();
    logic [31:0] q;
    logic [7:0]  b;
    set_ctrl(1, 1, 30);
    cpu(1, 1, 32'h4433_2211, q);
    cpu(1, 1, 32'h0000_00EE, q);  // partial tail word: one byte meaningful
    for (int i = 0; i < 4; i++) begin
      eng(0, 120 + i, 0, b);
      chk("R9 engine lane", {24'd0, b}, 32'h11 * (i + 1));
    end
    eng(0, 124, 0, b);
    chk("R9 tail low byte", {24'd0, b}, 32'hEE);
    eng(1, 122, 8'hAB, b);
    set_ctrl(0, 0, 30);
    cpu(1, 0, 0, q);
    chk("R10 engine byte write", q, 32'h44AB_2211);
  endtask

  task automatic t_collide();
    logic [31:0] q;
    set_ctrl(1, 0, 40);
    cpu(1, 1, 32'h0102_0304, q);
    set_ctrl(0, 0, 40);
    @(negedge clk);
    cpu_req = 1; cpu_sel = 1; cpu_we = 0;
    eng_en = 1; eng_we = 1; eng_addr = 9'd161; eng_wdata = 8'h99;
    @(negedge clk);
    cpu_req = 0; eng_en = 0; eng_we = 0;
    chk("R11 read sees old", cpu_rdata, 32'h0102_0304);
    cpu(1, 0, 0, q);
    chk("R11 engine byte landed", q, 32'h0102_9904);
    set_ctrl(1, 0, 40);
    @(negedge clk);
    cpu_req = 1; cpu_sel = 1; cpu_we = 1; cpu_wdata = 32'hFFFF_FFFF;
    eng_en = 1; eng_we = 1; eng_addr = 9'd160; eng_wdata = 8'h55;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; eng_en = 0; eng_we = 0;
    set_ctrl(0, 0, 40);
    cpu(1, 0, 0, q);
    chk("R11 cpu write dropped", q, 32'h0102_9955);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_stream();
    t_wrap();
    t_noauto();
    t_ignore();
    t_rd_in_wr();
    t_endian();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule